// File: doc/BRIEF.md
# Hot-Swap Fault and Retry Sequencer

This block is the digital sequencing core of a hot-swap power controller. It receives comparator outputs from the analog front end: load overcurrent above the breaker threshold, input overvoltage, undervoltage-valid, enable, on request, internal-supply-good, timer-below-threshold and power-good. It turns these into a gate-enable command for the external pass transistor. It records sticky fault flags, drives an open-drain power indication of selectable polarity, and drives an active-low alert.

An overcurrent must persist through a filter window before it counts as a fault. The filter window is short or long, selected by a build parameter. When a fault is counted, the gate is dropped and the block enters a cool-down. The cool-down ends in one of two ways. If the timer pin is strapped high, an internal counter of fixed length ends it. Otherwise it ends when the external timer comparator reports a discharged capacitor. After cool-down the block either retries on its own, or it holds the gate off until the host clears the overcurrent flag. An overvoltage removes the gate at once, with no filtering. A rising edge of the internal-supply-good signal re-initializes all state.

All comparator inputs pass through multi-flop synchronizers. The asynchronous reset is released synchronously.

Top module: `hsw_fault_ctrl`

## Requirements
- R1: While reset is active, gate_en is 0, flt_status is 0 and alert_n is 1.
- R2: An overcurrent fault counts only when the synchronized oc_cmp stays high for more than FILT sampled cycles in a row. FILT is FAST_FILT_CYC, or SLOW_FILT_CYC when USE_SLOW_FILT is 1.
- R3: When an overcurrent fault counts while the gate is on, gate_en falls on the next clock and flt_status bit 0 (overcurrent) sets.
- R4: Any low cycle of the synchronized oc_cmp restarts the filter window from zero.
- R5: With tmr_strap low, cool-down lasts until the synchronized tmr_low is high, however long that takes.
- R6: With tmr_strap high, cool-down lasts exactly COOL_CYC cycles. The gate re-enables two cycles after the count completes.
- R7: With retry_en low, the gate stays off after cool-down until the host clears flt_status bit 0.
- R8: A synchronized ov_cmp high turns gate_en off on the next clock and sets flt_status bit 1 (overvoltage), with no filter.
- R9: gate_en rises only when uvlo_good, uv_ok, en_ok and on_req are all high and ov_cmp is low (after synchronization). It falls when any of these conditions is lost.
- R10: A rising edge of the synchronized uvlo_good clears flt_status and returns the sequencer to its off state.
- R11: Power is good when gate_en is high and the synchronized pg_cmp is high. With pg_pol_bad at 0, pg_pull is high when power is not good. With pg_pol_bad at 1, pg_pull is high when power is good.
- R12: alert_n is low exactly when a flt_status bit is set whose alert_mask bit is set. Bit 0 is overcurrent and bit 1 is overvoltage.
- R13: flt_status bits are sticky. A cycle with clr_we high clears each bit whose clr_data bit is 1, unless that fault is being set in the same cycle; setting wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oc_cmp | input | 1 | Sense voltage above breaker threshold |
| ov_cmp | input | 1 | Input overvoltage |
| uv_ok | input | 1 | Input above undervoltage threshold |
| en_ok | input | 1 | Enable condition valid |
| on_req | input | 1 | On request |
| uvlo_good | input | 1 | Internal supply above lockout |
| tmr_low | input | 1 | Timer capacitor below low threshold |
| tmr_strap | input | 1 | Timer pin strapped high: use internal cool-down |
| pg_cmp | input | 1 | Output voltage above power-good threshold |
| retry_en | input | 1 | Auto-retry after overcurrent cool-down |
| pg_pol_bad | input | 1 | Power indication polarity select |
| alert_mask | input | 2 | Per-fault alert enable (bit0 OC, bit1 OV) |
| clr_we | input | 1 | Fault clear strobe |
| clr_data | input | 2 | Write-one-to-clear fault mask |
| gate_en | output | 1 | Pass transistor gate enable |
| flt_status | output | 2 | Sticky faults (bit0 OC, bit1 OV) |
| pg_pull | output | 1 | Open-drain pull-down request |
| alert_n | output | 1 | Active-low alert |

## Verification
The bench builds the block with FAST_FILT_CYC=3, SLOW_FILT_CYC=7 and COOL_CYC=12. It uses two instances that differ only in filter selection. With windows this short, every overcurrent pulse length from one cycle to past the long window can be swept, so the exact trip boundary of both variants is checked. The internal cool-down can be counted cycle by cycle, and the bench checks the edge on which the gate returns.

// File: rtl/hsw_pkg.sv
package hsw_pkg;
  typedef enum logic [1:0] {ST_OFF, ST_ON, ST_COOL, ST_HOLD} hsw_state_e;
  localparam int FLT_OC  = 0;
  localparam int FLT_OV  = 1;
  localparam int NUM_FLT = 2;
  localparam int IX_OC   = 0;
  localparam int IX_OV   = 1;
  localparam int IX_UV   = 2;
  localparam int IX_EN   = 3;
  localparam int IX_ON   = 4;
  localparam int IX_UVLO = 5;
  localparam int IX_TMR  = 6;
  localparam int IX_STRP = 7;
  localparam int IX_PG   = 8;
  localparam int NUM_IN  = 9;
endpackage

// File: rtl/hsw_sync.sv
module hsw_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/hsw_oc_filter.sv
module hsw_oc_filter #(
  parameter int LIMIT = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic oc_s,
  output logic trip
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] CMAX = CW'(LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = init || !oc_s || (cnt_q != CMAX);
    if (init || !oc_s) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign trip = oc_s && (cnt_q == CMAX) && !init;

  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CMAX);
  a_r4_low_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    !oc_s |=> !trip);
endmodule

// File: rtl/hsw_cool_timer.sv
module hsw_cool_timer #(
  parameter int COOL_CYC = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(COOL_CYC + 1);
  localparam logic [CW-1:0] CMAX = CW'(COOL_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = !run || (cnt_q != CMAX);
    cnt_d  = run ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = run && (cnt_q == CMAX);

  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CMAX);
  a_r6_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !done);
endmodule

// File: rtl/hsw_fault_ctrl.sv
module hsw_fault_ctrl
  import hsw_pkg::*;
#(
  parameter int FAST_FILT_CYC = 200,
  parameter int SLOW_FILT_CYC = 4200,
  parameter bit USE_SLOW_FILT = 1'b0,
  parameter int COOL_CYC      = 50_000_000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               oc_cmp,
  input  logic               ov_cmp,
  input  logic               uv_ok,
  input  logic               en_ok,
  input  logic               on_req,
  input  logic               uvlo_good,
  input  logic               tmr_low,
  input  logic               tmr_strap,
  input  logic               pg_cmp,
  input  logic               retry_en,
  input  logic               pg_pol_bad,
  input  logic [NUM_FLT-1:0] alert_mask,
  input  logic               clr_we,
  input  logic [NUM_FLT-1:0] clr_data,
  output logic               gate_en,
  output logic [NUM_FLT-1:0] flt_status,
  output logic               pg_pull,
  output logic               alert_n
);
  localparam int FILT_CYC = USE_SLOW_FILT ? SLOW_FILT_CYC : FAST_FILT_CYC;

  // reset release synchronizer
  logic [1:0] rst_sq;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= '0;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_int_n = rst_sq[1];

  // comparator synchronization
  logic [NUM_IN-1:0] raw_in, syn;
  always_comb begin
    raw_in          = '0;
    raw_in[IX_OC]   = oc_cmp;
    raw_in[IX_OV]   = ov_cmp;
    raw_in[IX_UV]   = uv_ok;
    raw_in[IX_EN]   = en_ok;
    raw_in[IX_ON]   = on_req;
    raw_in[IX_UVLO] = uvlo_good;
    raw_in[IX_TMR]  = tmr_low;
    raw_in[IX_STRP] = tmr_strap;
    raw_in[IX_PG]   = pg_cmp;
  end

  hsw_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d(raw_in), .q(syn)
  );

  // power-up initialization on supply-good rising edge
  logic uvlo_q, uvlo_rise;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) uvlo_q <= 1'b0;
    else            uvlo_q <= syn[IX_UVLO];
  end
  assign uvlo_rise = syn[IX_UVLO] && !uvlo_q;

  // overcurrent filter and cool-down timer
  hsw_state_e state_q, state_d;
  logic       oc_trip, int_done, cool_done, cond_ok;

  hsw_oc_filter #(.LIMIT(FILT_CYC)) u_filt (
    .clk(clk), .rst_n(rst_int_n), .init(uvlo_rise),
    .oc_s(syn[IX_OC]), .trip(oc_trip)
  );

  hsw_cool_timer #(.COOL_CYC(COOL_CYC)) u_cool (
    .clk(clk), .rst_n(rst_int_n), .run(state_q == ST_COOL), .done(int_done)
  );

  assign cond_ok   = syn[IX_UVLO] && syn[IX_UV] && syn[IX_EN] &&
                     syn[IX_ON] && !syn[IX_OV];
  assign cool_done = syn[IX_STRP] ? int_done : syn[IX_TMR];

  // sequencer next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:  if (cond_ok) state_d = ST_ON;
      ST_ON: begin
        if (syn[IX_OV])   state_d = ST_OFF;
        else if (oc_trip) state_d = ST_COOL;
        else if (!cond_ok) state_d = ST_OFF;
      end
      ST_COOL: if (cool_done) state_d = retry_en ? ST_OFF : ST_HOLD;
      ST_HOLD: if (!flt_status[FLT_OC]) state_d = ST_OFF;
      default: state_d = ST_OFF;
    endcase
    if (uvlo_rise) state_d = ST_OFF;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) state_q <= ST_OFF;
    else            state_q <= state_d;
  end

  assign gate_en = (state_q == ST_ON);

  // sticky fault flags
  logic [NUM_FLT-1:0] flt_set, flt_q;
  always_comb begin
    flt_set         = '0;
    flt_set[FLT_OC] = oc_trip;
    flt_set[FLT_OV] = syn[IX_OV];
  end

  for (genvar i = 0; i < NUM_FLT; i++) begin : g_flt
    logic bit_d, bit_en;
    always_comb begin
      bit_en = uvlo_rise || flt_set[i] || (clr_we && clr_data[i]);
      bit_d  = uvlo_rise ? 1'b0 : flt_set[i];
    end
    always_ff @(posedge clk or negedge rst_int_n) begin
      if (!rst_int_n)  flt_q[i] <= 1'b0;
      else if (bit_en) flt_q[i] <= bit_d;
    end

    a_r13_sticky: assert property (@(posedge clk) disable iff (!rst_int_n)
      (flt_q[i] && !(clr_we && clr_data[i]) && !uvlo_rise) |=> flt_q[i]);
    a_r13_set_wins: assert property (@(posedge clk) disable iff (!rst_int_n)
      (flt_set[i] && !uvlo_rise) |=> flt_q[i]);
  end

  assign flt_status = flt_q;

  // indications
  logic pwr_good;
  assign pwr_good = gate_en && syn[IX_PG];
  assign pg_pull  = pg_pol_bad ? pwr_good : !pwr_good;
  assign alert_n  = ~|(flt_q & alert_mask);

  a_r3_gate_off_on_trip: assert property (@(posedge clk) disable iff (!rst_int_n)
    (gate_en && oc_trip) |=> !gate_en);
  a_r8_ov_gate_off: assert property (@(posedge clk) disable iff (!rst_int_n)
    syn[IX_OV] |=> !gate_en);
  a_r9_gate_needs_cond: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(gate_en) |-> $past(cond_ok));
  a_r7_hold_gate_off: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == ST_HOLD && flt_q[FLT_OC]) |=> !gate_en);
  a_r10_init_clears: assert property (@(posedge clk) disable iff (!rst_int_n)
    uvlo_rise |=> (flt_q == '0 && !gate_en));
endmodule

// File: tb/hsw_fault_ctrl_test.sv
module hsw_fault_ctrl_test;
  localparam int FAST = 3;
  localparam int SLOW = 7;
  localparam int COOL = 12;

  logic clk = 1'b0;
  logic rst_n, oc_cmp, ov_cmp, uv_ok, en_ok, on_req, uvlo_good;
  logic tmr_low, tmr_strap, pg_cmp, retry_en, pg_pol_bad, clr_we;
  logic [1:0] alert_mask, clr_data;
  logic gate_en, pg_pull, alert_n, gate_slow, pg_s, al_s;
  logic [1:0] flt_status, st_slow;

  int checks = 0;
  int errs   = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  hsw_fault_ctrl #(.FAST_FILT_CYC(FAST), .SLOW_FILT_CYC(SLOW), .USE_SLOW_FILT(1'b0),
                   .COOL_CYC(COOL)) uut (
    .clk(clk), .rst_n(rst_n), .oc_cmp(oc_cmp), .ov_cmp(ov_cmp), .uv_ok(uv_ok),
    .en_ok(en_ok), .on_req(on_req), .uvlo_good(uvlo_good), .tmr_low(tmr_low),
    .tmr_strap(tmr_strap), .pg_cmp(pg_cmp), .retry_en(retry_en),
    .pg_pol_bad(pg_pol_bad), .alert_mask(alert_mask), .clr_we(clr_we),
    .clr_data(clr_data), .gate_en(gate_en), .flt_status(flt_status),
    .pg_pull(pg_pull), .alert_n(alert_n));

  hsw_fault_ctrl #(.FAST_FILT_CYC(FAST), .SLOW_FILT_CYC(SLOW), .USE_SLOW_FILT(1'b1),
                   .COOL_CYC(COOL)) uut_slow (
    .clk(clk), .rst_n(rst_n), .oc_cmp(oc_cmp), .ov_cmp(ov_cmp), .uv_ok(uv_ok),
    .en_ok(en_ok), .on_req(on_req), .uvlo_good(uvlo_good), .tmr_low(tmr_low),
    .tmr_strap(tmr_strap), .pg_cmp(pg_cmp), .retry_en(retry_en),
    .pg_pol_bad(pg_pol_bad), .alert_mask(alert_mask), .clr_we(clr_we),
    .clr_data(clr_data), .gate_en(gate_slow), .flt_status(st_slow),
    .pg_pull(pg_s), .alert_n(al_s));

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start(input logic strap, input logic retry);
    rst_n = 1'b0;
    oc_cmp = 0; ov_cmp = 0; uv_ok = 1; en_ok = 1; on_req = 1; uvlo_good = 1;
    tmr_low = 0; tmr_strap = strap; pg_cmp = 1; retry_en = retry;
    pg_pol_bad = 0; alert_mask = 2'b11; clr_we = 0; clr_data = 2'b00;
    tick(3);
    rst_n = 1'b1;
    tick(8);
  endtask

  task automatic w1c(input logic [1:0] m);
    clr_we = 1'b1; clr_data = m;
    tick(1);
    clr_we = 1'b0; clr_data = 2'b00;
  endtask

  initial begin
    // R1 reset state
    start(1'b1, 1'b1);
    rst_n = 1'b0;
    tick(1);
    check("R1 gate", gate_en, 0);
    check("R1 status", flt_status, 0);
    check("R1 alert_n", alert_n, 1);
    rst_n = 1'b1;
    tick(8);
    check("R9 gate on with all conditions", gate_en, 1);

    // R2 sweep of pulse length over both filter variants
    for (int n = 1; n <= SLOW + 2; n++) begin
      start(1'b1, 1'b1);
      oc_cmp = 1'b1;
      tick(n);
      oc_cmp = 1'b0;
      tick(4);
      check($sformatf("R2 fast gate n=%0d", n), gate_en, (n > FAST) ? 0 : 1);
      check($sformatf("R2 fast flag n=%0d", n), flt_status[0], (n > FAST) ? 1 : 0);
      check($sformatf("R2 slow gate n=%0d", n), gate_slow, (n > SLOW) ? 0 : 1);
    end

    // R4 a single low cycle restarts the window
    start(1'b1, 1'b1);
    oc_cmp = 1; tick(FAST); oc_cmp = 0; tick(1); oc_cmp = 1; tick(FAST); oc_cmp = 0;
    tick(4);
    check("R4 gate stays on", gate_en, 1);
    check("R4 no flag", flt_status[0], 0);

    // R3 exact trip edge, R6 internal cool-down length
    start(1'b1, 1'b1);
    oc_cmp = 1'b1;
    tick(FAST + 2);
    check("R3 gate before trip edge", gate_en, 1);
    tick(1);
    check("R3 gate off after trip", gate_en, 0);
    check("R3 oc flag", flt_status[0], 1);
    oc_cmp = 1'b0;
    tick(COOL + 1);
    check("R6 gate still off", gate_en, 0);
    tick(1);
    check("R6 gate back after cool-down", gate_en, 1);

    // R5 external timer cool-down
    start(1'b0, 1'b1);
    oc_cmp = 1; tick(FAST + 3); oc_cmp = 0;
    tick(30);
    check("R5 waits for timer", gate_en, 0);
    tmr_low = 1'b1;
    tick(4);
    check("R5 gate after timer low", gate_en, 1);

    // R7 no retry
    start(1'b1, 1'b0);
    oc_cmp = 1; tick(FAST + 3); oc_cmp = 0;
    tick(COOL + 10);
    check("R7 gate held off", gate_en, 0);
    w1c(2'b01);
    tick(3);
    check("R7 gate after clear", gate_en, 1);
    check("R7 flag cleared", flt_status[0], 0);

    // R13 set wins over clear, R12 alert masking
    start(1'b1, 1'b1);
    oc_cmp = 1'b1;
    tick(FAST + 5);
    check("R12 alert on oc", alert_n, 0);
    alert_mask = 2'b10;
    #1;
    check("R12 alert masked", alert_n, 1);
    alert_mask = 2'b11;
    w1c(2'b01);
    check("R13 set wins", flt_status[0], 1);
    oc_cmp = 1'b0;
    tick(4);
    w1c(2'b10);
    check("R13 other bit clear leaves oc", flt_status[0], 1);
    w1c(2'b01);
    check("R13 cleared", flt_status[0], 0);
    check("R12 alert released", alert_n, 1);

    // R8 overvoltage
    start(1'b1, 1'b1);
    ov_cmp = 1'b1;
    tick(2);
    check("R8 gate before sync", gate_en, 1);
    tick(1);
    check("R8 gate off", gate_en, 0);
    check("R8 ov flag", flt_status[1], 1);
    check("R12 alert on ov", alert_n, 0);
    ov_cmp = 1'b0;
    tick(4);
    check("R8 gate returns", gate_en, 1);
    check("R8 flag sticky", flt_status[1], 1);

    // R10 supply-good rising edge initializes
    uvlo_good = 1'b0;
    tick(4);
    check("R9 gate off without supply", gate_en, 0);
    check("R10 flag kept while low", flt_status[1], 1);
    uvlo_good = 1'b1;
    tick(3);
    check("R10 flags cleared", flt_status, 0);
    tick(2);
    check("R10 gate on after init", gate_en, 1);

    // R9 each enable condition
    for (int k = 0; k < 3; k++) begin
      start(1'b1, 1'b1);
      if (k == 0) uv_ok = 0; else if (k == 1) en_ok = 0; else on_req = 0;
      tick(4);
      check($sformatf("R9 cond %0d lost", k), gate_en, 0);
      uv_ok = 1; en_ok = 1; on_req = 1;
      tick(4);
      check($sformatf("R9 cond %0d back", k), gate_en, 1);
    end

    // R11 power indication polarity
    start(1'b1, 1'b1);
    check("R11 good, normal", pg_pull, 0);
    pg_pol_bad = 1'b1;
    #1;
    check("R11 good, inverted", pg_pull, 1);
    pg_cmp = 1'b0;
    tick(3);
    check("R11 bad, inverted", pg_pull, 0);
    pg_pol_bad = 1'b0;
    #1;
    check("R11 bad, normal", pg_pull, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule